// File: doc/BRIEF.md
# Nibble-Coded Multi-Cycle Processor Core

This block is a small processor core that runs in several cycles per instruction. It takes 16-bit instruction words from an internal program store that holds 1024 words. It works on sixteen 8-bit general registers and a 256-byte data store. The core has no flags and no accumulator. Every operation names a register directly, and the only conditional control flow is a test of a register for zero.

Software fills the program store through a write port while the core is stopped. It then pulses the start input together with the instruction count. The core executes from index 0 until its program counter reaches that count, and then raises halted. If it meets an opcode it does not know, it stops and raises error instead. Two combinational debug taps let the surrounding logic read any register or any data byte at any time.

Each instruction takes three cycles: fetch, decode and execute. An instruction that reads the data store takes one more cycle, and so does a read-modify-write of the data store.

Top module: `nib_core`

## Requirements
- R1: After reset, busy_o, halted_o and error_o are low, and every register, every data byte and every program word reads zero.
- R2: An instruction word is split into an opcode in bits [15:12], a register number Rn in bits [11:8] and an argument byte in bits [7:0]. The second register number Rm is the upper nibble of the argument byte, bits [7:4].
- R3: Opcode 0x0 copies the data byte at the argument address into Rn. Opcode 0x1 writes Rn to the data byte at the argument address.
- R4: Opcode 0x2 writes Rm to the data byte addressed by the value in Rn. Opcode 0x3 loads the argument byte into Rn.
- R5: Opcode 0x4 sets Rn to Rn+Rm and opcode 0x5 sets Rn to Rn-Rm. Both wrap modulo 256.
- R6: Opcode 0x6 tests Rn. If Rn is zero, the next instruction is the one at the index in bits [3:0], zero-extended. Otherwise execution goes on to the next index.
- R7: Opcode 0x7 increments Rn and opcode 0xA decrements Rn, both wrapping modulo 256.
- R8: Opcode 0x8 increments, and opcode 0xB decrements, the data byte addressed by the value in Rn, both wrapping modulo 256.
- R9: Opcode 0x9 increments, and opcode 0xC decrements, the data byte at the argument address, both wrapping modulo 256.
- R10: A start_i pulse while the core is not busy latches prog_len_i, restarts at index 0 and raises busy_o on the next cycle. Registers and data are kept. A start_i pulse while the core is busy is ignored.
- R11: When the program counter is greater than or equal to the latched count, the core stops with halted_o high and busy_o low. This covers a count of zero and a jump past the count. The core stays halted until the next start.
- R12: Opcodes 0xD, 0xE and 0xF write nothing. They stop the core with error_o high and busy_o low until the next start.
- R13: A write on the load port stores load_data_i at word load_addr_i only while the core is not busy. A write while the core is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_en_i | input | 1 | Program store write strobe |
| load_addr_i | input | 10 | Program word index to write |
| load_data_i | input | 16 | Program word to write |
| prog_len_i | input | 11 | Instruction count, sampled at start |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Program executing |
| halted_o | output | 1 | Stopped at the end of the program |
| error_o | output | 1 | Stopped on an unknown opcode |
| dbg_reg_sel_i | input | 4 | Register debug read index |
| dbg_reg_o | output | 8 | Selected register value |
| dbg_mem_sel_i | input | 8 | Data byte debug read address |
| dbg_mem_o | output | 8 | Selected data byte |

## Verification
Three fixed programs check the core against a bench model of the instruction set. A count-down summing loop exercises taken and not-taken zero tests and backward jumps. A Fibonacci writer exercises indirect stores and register increment and decrement. A straight-line program hits every opcode, including wrap at 0x00 and 0xFF, and so separates the direct, indirect and register forms of each operation.

Random programs mix all opcodes, forward-only jumps that can land past the count, and a few unknown opcodes, with addresses packed close together so that loads and stores collide. Short directed cases cover a count of zero, a jump beyond the end, an unknown opcode stopping mid-program, and a restart and a program write arriving while the core is busy.

// File: rtl/nib_core_pkg.sv
package nib_core_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  localparam logic [3:0] OP_LOAD  = 4'h0;
  localparam logic [3:0] OP_STORE = 4'h1;
  localparam logic [3:0] OP_STIND = 4'h2;
  localparam logic [3:0] OP_IMM   = 4'h3;
  localparam logic [3:0] OP_ADD   = 4'h4;
  localparam logic [3:0] OP_SUB   = 4'h5;
  localparam logic [3:0] OP_JZ    = 4'h6;
  localparam logic [3:0] OP_INC_R = 4'h7;
  localparam logic [3:0] OP_INC_I = 4'h8;
  localparam logic [3:0] OP_INC_D = 4'h9;
  localparam logic [3:0] OP_DEC_R = 4'hA;
  localparam logic [3:0] OP_DEC_I = 4'hB;
  localparam logic [3:0] OP_DEC_D = 4'hC;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] rn;
    logic [7:0] arg;
  } instr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_HALT, ST_ERR
  } state_e;

  typedef enum logic [2:0] {
    RO_NONE, RO_IMM, RO_ADD, RO_SUB, RO_INC, RO_DEC, RO_LOAD
  } reg_op_e;

  typedef struct packed {
    logic    legal;
    logic    rd_mem;   // needs the extra memory cycle
    logic    wr_mem;   // store in execute
    logic    ind;      // address from Rn
    logic    step_mem; // read-modify-write of data byte
    logic    step_dn;
    logic    jz;
    reg_op_e reg_op;
  } ctrl_t;

endpackage

// File: rtl/nib_pmem.sv
module nib_pmem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else if (re_i) rdata_o <= mem_q[addr_i];
    end
  end

endmodule

// File: rtl/nib_dmem.sv
module nib_dmem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [AW-1:0]    dbg_addr_i,
  output logic [WIDTH-1:0] dbg_data_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else if (re_i) rdata_o <= mem_q[addr_i];
    end
  end

  assign dbg_data_o = mem_q[dbg_addr_i];

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned RA_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RA_W-1:0]  waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [RA_W-1:0]  raddr_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic [RA_W-1:0]  raddr_b_i,
  output logic [WIDTH-1:0] rdata_b_o,
  input  logic [RA_W-1:0]  dbg_addr_i,
  output logic [WIDTH-1:0] dbg_data_o
);

  logic [WIDTH-1:0] regs_q [NREGS];
  logic [NREGS-1:0] wen;

  for (genvar g = 0; g < NREGS; g++) begin : g_wen
    assign wen[g] = we_i && (waddr_i == RA_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++)
        if (wen[i]) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o  = regs_q[raddr_a_i];
  assign rdata_b_o  = regs_q[raddr_b_i];
  assign dbg_data_o = regs_q[dbg_addr_i];

endmodule

// File: rtl/nib_decode.sv
module nib_decode
  import nib_core_pkg::*;
(
  input  instr_t ir_i,
  output ctrl_t  ctl_o
);

  always_comb begin
    ctl_o        = '0;
    ctl_o.legal  = 1'b1;
    ctl_o.reg_op = RO_NONE;
    case (ir_i.op)
      OP_LOAD:  begin ctl_o.rd_mem = 1'b1; ctl_o.reg_op = RO_LOAD; end
      OP_STORE: ctl_o.wr_mem = 1'b1;
      OP_STIND: begin ctl_o.wr_mem = 1'b1; ctl_o.ind = 1'b1; end
      OP_IMM:   ctl_o.reg_op = RO_IMM;
      OP_ADD:   ctl_o.reg_op = RO_ADD;
      OP_SUB:   ctl_o.reg_op = RO_SUB;
      OP_JZ:    ctl_o.jz = 1'b1;
      OP_INC_R: ctl_o.reg_op = RO_INC;
      OP_DEC_R: ctl_o.reg_op = RO_DEC;
      OP_INC_I: begin ctl_o.rd_mem = 1'b1; ctl_o.ind = 1'b1; ctl_o.step_mem = 1'b1; end
      OP_DEC_I: begin
        ctl_o.rd_mem = 1'b1; ctl_o.ind = 1'b1; ctl_o.step_mem = 1'b1; ctl_o.step_dn = 1'b1;
      end
      OP_INC_D: begin ctl_o.rd_mem = 1'b1; ctl_o.step_mem = 1'b1; end
      OP_DEC_D: begin ctl_o.rd_mem = 1'b1; ctl_o.step_mem = 1'b1; ctl_o.step_dn = 1'b1; end
      default:  ctl_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_core_pkg::*;
#(
  parameter int unsigned PMEM_DEPTH = 1024,
  parameter int unsigned DMEM_DEPTH = 256,
  parameter int unsigned NREGS      = 16,
  localparam int unsigned PA_W = $clog2(PMEM_DEPTH),
  localparam int unsigned PC_W = PA_W + 1,
  localparam int unsigned DA_W = $clog2(DMEM_DEPTH),
  localparam int unsigned RA_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [PA_W-1:0]   load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [PC_W-1:0]   prog_len_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              halted_o,
  output logic              error_o,
  input  logic [RA_W-1:0]   dbg_reg_sel_i,
  output logic [BYTE_W-1:0] dbg_reg_o,
  input  logic [DA_W-1:0]   dbg_mem_sel_i,
  output logic [BYTE_W-1:0] dbg_mem_o
);

  state_e            state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d, len_q;
  instr_t            ir_q;
  logic [DA_W-1:0]   maddr_q, exec_addr;
  ctrl_t             ctl;

  logic              pm_we, pm_re;
  logic [PA_W-1:0]   pm_addr;
  logic [WORD_W-1:0] pm_rdata;

  logic              dm_we, dm_re;
  logic [DA_W-1:0]   dm_addr;
  logic [BYTE_W-1:0] dm_wdata, dm_rdata;

  logic              rf_we;
  logic [BYTE_W-1:0] rf_wdata, rn_data, rm_data;

  assign busy_o   = (state_q == ST_FETCH) || (state_q == ST_DECODE) ||
                    (state_q == ST_EXEC)  || (state_q == ST_MEM);
  assign halted_o = (state_q == ST_HALT);
  assign error_o  = (state_q == ST_ERR);

  // program store: loads only while stopped
  assign pm_we   = load_en_i && !busy_o;
  assign pm_re   = (state_q == ST_FETCH) && (pc_q < len_q);
  assign pm_addr = pm_we ? load_addr_i : pc_q[PA_W-1:0];

  nib_pmem #(.DEPTH(PMEM_DEPTH), .WIDTH(WORD_W)) u_pmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pm_we),
    .re_i    (pm_re),
    .addr_i  (pm_addr),
    .wdata_i (load_data_i),
    .rdata_o (pm_rdata)
  );

  nib_decode u_dec (
    .ir_i  (ir_q),
    .ctl_o (ctl)
  );

  nib_regfile #(.NREGS(NREGS), .WIDTH(BYTE_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (rf_we),
    .waddr_i    (ir_q.rn[RA_W-1:0]),
    .wdata_i    (rf_wdata),
    .raddr_a_i  (ir_q.rn[RA_W-1:0]),
    .rdata_a_o  (rn_data),
    .raddr_b_i  (ir_q.arg[7 -: RA_W]),
    .rdata_b_o  (rm_data),
    .dbg_addr_i (dbg_reg_sel_i),
    .dbg_data_o (dbg_reg_o)
  );

  nib_dmem #(.DEPTH(DMEM_DEPTH), .WIDTH(BYTE_W)) u_dmem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (dm_we),
    .re_i       (dm_re),
    .addr_i     (dm_addr),
    .wdata_i    (dm_wdata),
    .rdata_o    (dm_rdata),
    .dbg_addr_i (dbg_mem_sel_i),
    .dbg_data_o (dbg_mem_o)
  );

  assign exec_addr = ctl.ind ? rn_data[DA_W-1:0] : ir_q.arg[DA_W-1:0];

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    dm_we    = 1'b0;
    dm_re    = 1'b0;
    dm_addr  = exec_addr;
    dm_wdata = ctl.ind ? rm_data : rn_data;
    rf_we    = 1'b0;
    rf_wdata = '0;
    case (state_q)
      ST_IDLE, ST_HALT, ST_ERR: begin
        if (start_i) begin
          state_d = ST_FETCH;
          pc_d    = '0;
        end
      end
      ST_FETCH:  state_d = (pc_q >= len_q) ? ST_HALT : ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        if (!ctl.legal) begin
          state_d = ST_ERR;
        end else begin
          dm_we = ctl.wr_mem;
          case (ctl.reg_op)
            RO_IMM: begin rf_we = 1'b1; rf_wdata = ir_q.arg; end
            RO_ADD: begin rf_we = 1'b1; rf_wdata = rn_data + rm_data; end
            RO_SUB: begin rf_we = 1'b1; rf_wdata = rn_data - rm_data; end
            RO_INC: begin rf_we = 1'b1; rf_wdata = rn_data + 8'd1; end
            RO_DEC: begin rf_we = 1'b1; rf_wdata = rn_data - 8'd1; end
            default: ;
          endcase
          if (ctl.rd_mem) begin
            dm_re   = 1'b1;
            state_d = ST_MEM;
          end else begin
            state_d = ST_FETCH;
            if (ctl.jz && (rn_data == '0)) pc_d = PC_W'(ir_q.arg[3:0]);
            else pc_d = pc_q + PC_W'(1);
          end
        end
      end
      ST_MEM: begin
        dm_addr = maddr_q;
        if (ctl.reg_op == RO_LOAD) begin
          rf_we    = 1'b1;
          rf_wdata = dm_rdata;
        end
        if (ctl.step_mem) begin
          dm_we    = 1'b1;
          dm_wdata = ctl.step_dn ? dm_rdata - 8'd1 : dm_rdata + 8'd1;
        end
        pc_d    = pc_q + PC_W'(1);
        state_d = ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      len_q   <= '0;
      ir_q    <= '0;
      maddr_q <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      if (!busy_o && start_i) len_q <= prog_len_i;
      if (state_q == ST_DECODE) ir_q <= pm_rdata;
      if (state_q == ST_EXEC) maddr_q <= exec_addr;
    end
  end

endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic halted_o,
  input logic error_o,
  input logic rf_we,
  input logic dm_we
);

  // R11
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, halted_o, error_o}));

  // R11
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !start_i |=> halted_o);

  // R12
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !start_i |=> error_o);

  // R10
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);

  // R12
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> $past(!rf_we && !dm_we));

endmodule

bind nib_core nib_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .halted_o (halted_o),
  .error_o  (error_o),
  .rf_we    (rf_we),
  .dm_we    (dm_we)
);

// File: tb/nib_core_test.sv
module nib_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [9:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [10:0] prog_len = '0;
  logic        start = 1'b0;
  logic        busy, halted, error;
  logic [3:0]  dbg_reg_sel = '0;
  logic [7:0]  dbg_reg;
  logic [7:0]  dbg_mem_sel = '0;
  logic [7:0]  dbg_mem;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] img  [1024];
  logic [7:0]  rreg [16];
  logic [7:0]  rmem [256];
  bit          ref_err;

  always #4 clk = ~clk;

  nib_core uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .load_en_i     (load_en),
    .load_addr_i   (load_addr),
    .load_data_i   (load_data),
    .prog_len_i    (prog_len),
    .start_i       (start),
    .busy_o        (busy),
    .halted_o      (halted),
    .error_o       (error),
    .dbg_reg_sel_i (dbg_reg_sel),
    .dbg_reg_o     (dbg_reg),
    .dbg_mem_sel_i (dbg_mem_sel),
    .dbg_mem_o     (dbg_mem)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int r, input logic [7:0] exp);
    dbg_reg_sel = 4'(r);
    #1;
    check(tag, 32'(dbg_reg), 32'(exp));
  endtask

  task automatic chk_mem(input string tag, input int a, input logic [7:0] exp);
    dbg_mem_sel = 8'(a);
    #1;
    check(tag, 32'(dbg_mem), 32'(exp));
  endtask

  task automatic compare_all(input string tag);
    for (int r = 0; r < 16; r++) chk_reg($sformatf("%s reg %0d", tag, r), r, rreg[r]);
    for (int a = 0; a < 256; a++) chk_mem($sformatf("%s mem %0d", tag, a), a, rmem[a]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; load_en = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 1024; i++) img[i] = '0;
    for (int i = 0; i < 16; i++) rreg[i] = '0;
    for (int i = 0; i < 256; i++) rmem[i] = '0;
  endtask

  task automatic load_prog(input int len);
    for (int i = 0; i < len; i++) begin
      load_en = 1'b1; load_addr = 10'(i); load_data = img[i];
      @(negedge clk);
    end
    load_en = 1'b0;
  endtask

  task automatic wait_stop();
    int cnt = 0;
    while (!(halted || error) && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    if (cnt >= 20000) check("R11 run did not stop", 32'(busy), 32'(0));
  endtask

  task automatic run_hw(input int len);
    prog_len = 11'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", 32'(busy), 32'(1));
    wait_stop();
  endtask

  // bench model of the instruction set
  task automatic ref_run(input int len);
    int pc = 0;
    int steps = 0;
    ref_err = 1'b0;
    while (pc < len && steps < 5000) begin
      logic [15:0] w = img[pc];
      logic [3:0] op = w[15:12];
      logic [3:0] rn = w[11:8];
      logic [3:0] rm = w[7:4];
      logic [7:0] b  = w[7:0];
      int npc = pc + 1;
      steps++;
      case (op)
        4'h0: rreg[rn] = rmem[b];
        4'h1: rmem[b] = rreg[rn];
        4'h2: rmem[rreg[rn]] = rreg[rm];
        4'h3: rreg[rn] = b;
        4'h4: rreg[rn] = rreg[rn] + rreg[rm];
        4'h5: rreg[rn] = rreg[rn] - rreg[rm];
        4'h6: if (rreg[rn] == 8'd0) npc = int'(b[3:0]);
        4'h7: rreg[rn] = rreg[rn] + 8'd1;
        4'h8: rmem[rreg[rn]] = rmem[rreg[rn]] + 8'd1;
        4'h9: rmem[b] = rmem[b] + 8'd1;
        4'hA: rreg[rn] = rreg[rn] - 8'd1;
        4'hB: rmem[rreg[rn]] = rmem[rreg[rn]] - 8'd1;
        4'hC: rmem[b] = rmem[b] - 8'd1;
        default: begin ref_err = 1'b1; return; end
      endcase
      pc = npc;
    end
  endtask

  function automatic logic [15:0] rand_word(input int idx);
    logic [3:0] op = 4'($urandom_range(0, 12));
    logic [3:0] rn = 4'($urandom_range(0, 15));
    logic [7:0] b  = 8'($urandom_range(0, 255));
    if ($urandom_range(0, 39) == 0) op = 4'($urandom_range(13, 15));
    if (op == 4'h0 || op == 4'h1 || op == 4'h9 || op == 4'hC) b = 8'($urandom_range(0, 31));
    if (op == 4'h6) begin
      if (idx < 15) b[3:0] = 4'($urandom_range(idx + 1, 15));
      else op = 4'h3;
    end
    return {op, rn, b};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] fib [10];
    void'($urandom(32'h1F3A_77C1));

    // R1 reset state
    do_reset();
    check("R1 busy at reset", 32'(busy), 32'(0));
    check("R1 halted at reset", 32'(halted), 32'(0));
    check("R1 error at reset", 32'(error), 32'(0));
    compare_all("R1 reset");

    // R6 count-down summing loop with backward jump
    do_reset();
    img[0] = 16'h3000; img[1] = 16'h310A; img[2] = 16'h3201; img[3] = 16'h3300;
    img[4] = 16'h6108; img[5] = 16'h4010; img[6] = 16'h5120; img[7] = 16'h6304;
    img[8] = 16'h38FF;
    load_prog(9); run_hw(9); ref_run(9);
    chk_reg("R6 sum R0", 0, 8'd55);
    chk_reg("R6 sum R1", 1, 8'd0);
    chk_reg("R6 sum R8", 8, 8'hFF);
    check("R11 sum halted", 32'(halted), 32'(1));
    compare_all("R6 sum");

    // R4 R7 Fibonacci into data bytes 0..9
    do_reset();
    img[0]  = 16'h3000; img[1]  = 16'h3101; img[2]  = 16'h3200; img[3]  = 16'h330A;
    img[4]  = 16'h3500; img[5]  = 16'h630F; img[6]  = 16'h2200; img[7]  = 16'h7200;
    img[8]  = 16'hA300; img[9]  = 16'h3600; img[10] = 16'h4610; img[11] = 16'h4100;
    img[12] = 16'h3000; img[13] = 16'h4060; img[14] = 16'h6505;
    load_prog(15); run_hw(15); ref_run(15);
    fib[0] = 8'd0; fib[1] = 8'd1;
    for (int k = 2; k < 10; k++) fib[k] = fib[k-1] + fib[k-2];
    for (int k = 0; k < 10; k++) chk_mem($sformatf("R4 fib value %0d", k), k, fib[k]);
    chk_reg("R7 fib pointer", 2, 8'd10);
    chk_reg("R7 fib counter", 3, 8'd0);
    compare_all("R4 fib");

    // every opcode, wrap cases
    do_reset();
    img[0]  = 16'h3105; img[1]  = 16'h3203; img[2]  = 16'h1110; img[3]  = 16'h0310;
    img[4]  = 16'h2210; img[5]  = 16'h4120; img[6]  = 16'h5230; img[7]  = 16'h7200;
    img[8]  = 16'h7200; img[9]  = 16'hA400; img[10] = 16'h8200; img[11] = 16'hB100;
    img[12] = 16'h9010; img[13] = 16'hC020; img[14] = 16'h35FF;
    load_prog(15); run_hw(15); ref_run(15);
    chk_reg("R3 load direct", 3, 8'd5);
    chk_mem("R4 store indirect", 3, 8'd5);
    chk_reg("R5 add", 1, 8'd8);
    chk_reg("R7 inc wraps to zero", 2, 8'd0);
    chk_reg("R7 dec wraps to FF", 4, 8'hFF);
    chk_reg("R4 immediate", 5, 8'hFF);
    chk_mem("R8 inc indirect", 0, 8'd1);
    chk_mem("R8 dec indirect", 8, 8'hFF);
    chk_mem("R9 inc direct", 16, 8'd6);
    chk_mem("R9 dec direct", 32, 8'hFF);
    compare_all("R3 R5 R8 R9 ops");

    // R6 jump past the count halts
    do_reset();
    img[0] = 16'h3000; img[1] = 16'h600F; img[2] = 16'h3177;
    load_prog(3); run_hw(3);
    check("R6 jump past end halted", 32'(halted), 32'(1));
    chk_reg("R6 skipped word", 1, 8'd0);

    // R12 unknown opcode mid-program
    do_reset();
    img[0] = 16'h3105; img[1] = 16'hD1FF; img[2] = 16'h3207;
    load_prog(3); run_hw(3);
    repeat (4) @(negedge clk);
    check("R12 error raised", 32'(error), 32'(1));
    check("R12 not halted", 32'(halted), 32'(0));
    check("R12 not busy", 32'(busy), 32'(0));
    chk_reg("R12 earlier write kept", 1, 8'd5);
    chk_reg("R12 later word not run", 2, 8'd0);

    // R11 zero count
    do_reset();
    run_hw(0);
    check("R11 zero count halted", 32'(halted), 32'(1));
    chk_reg("R11 zero count no effect", 0, 8'd0);

    // R10 R13 restart and program write while busy are ignored
    do_reset();
    for (int i = 0; i < 20; i++) img[i] = 16'h7100;
    load_prog(20);
    prog_len = 11'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    start = 1'b1; load_en = 1'b1; load_addr = 10'd19; load_data = 16'h3177;
    @(negedge clk);
    start = 1'b0; load_en = 1'b0;
    check("R10 still busy after second start", 32'(busy), 32'(1));
    wait_stop();
    chk_reg("R10 R13 count unchanged", 1, 8'd20);

    // R2 random programs
    for (int t = 0; t < 40; t++) begin
      int len;
      do_reset();
      len = $urandom_range(1, 24);
      for (int i = 0; i < len; i++) img[i] = rand_word(i);
      load_prog(len); run_hw(len); ref_run(len);
      check($sformatf("R12 random %0d error flag", t), 32'(error), 32'(ref_err));
      check($sformatf("R11 random %0d halted flag", t), 32'(halted), 32'(!ref_err));
      compare_all($sformatf("R2 random %0d", t));
    end

    finish_run();
  end

endmodule